// File: doc/BRIEF.md
# Two-Level Programmable Interrupt Router

The router collects 64 single-bit event lines from peripherals and delivers them to ten host interrupt lines. A rising edge on an event line latches a sticky pending bit. Each pending bit has its own enable. Routing passes through two tables that software can rewrite at any time. The first table assigns every event to one of ten channels. The second table assigns every channel to one of ten hosts. Both tables are many-to-one, so anything from a single event up to all 64 can converge on one host. Hosts 0 and 1 serve local cores, and hosts 2 to 9 leave the block as eight separate lines to an outside interrupt controller.

For each host, a read-only index word names the winning pending event. The winner is found by taking the lowest-numbered channel that feeds that host and has work, then the lowest-numbered event in that channel. A single-cycle register bus configures the block and reads it back. A write takes effect on the clock edge where `bus_wr` is high, and reads are combinational from `bus_addr`. Because the bus has no stream traffic, it has no valid/ready handshake and never applies back-pressure.

Top module: `intr_router`

## Requirements
- R1: After reset, all of these read zero: the pending bits, the enables, the global enable, both mapping tables and every host index word. `host_irq` is also zero.
- R2: A 0-to-1 change of `evt_in[e]` between two clock edges sets pending bit e on the next edge. A line that stays high does not set the bit again after it has been cleared.
- R3: A pending bit stays set until a 1 is written to its position in the clear words (address 6 for events 0-31, address 7 for events 32-63). If a rising edge on the same event arrives in the same cycle as the clear, the bit stays set. Reading addresses 4-7 returns the pending bits.
- R4: Writing a 1 to a position in the set words (address 4 for events 0-31, address 5 for events 32-63) sets that pending bit.
- R5: Addresses 2 and 3 hold the per-event enables, read/write, one bit per event. A disabled event still latches its pending bit, but it drives no host line and never shows up in an index word.
- R6: Addresses 16-23 hold the event-to-channel table as eight 4-bit fields per word. Event e sits at address 16+e/8, bits 4*(e%8)+3 down to 4*(e%8). A channel code of 10 or more routes the event nowhere.
- R7: Addresses 24-25 hold the channel-to-host table in the same field layout (channel c at address 24+c/8). A host code of 10 or more routes the channel nowhere.
- R8: `host_irq[h]` is high when the global enable is set and at least one enabled, pending event reaches host h through both tables. It is registered and follows a pending-bit change by one clock.
- R9: The index word of host h is at address 32+h. Bit 31 is valid, bits 11:8 hold the channel, and bits 5:0 hold the event. The winner is the lowest channel routed to h that has an enabled pending event, then the lowest such event within that channel. The word is all zero when nothing qualifies.
- R10: Bit 0 of address 0 is the global enable. When it is clear, every `host_irq` line is low, but latching and the index words still work.
- R11: Rewriting either table changes `host_irq` one clock after the write edge and changes the index words immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 64 | Event lines, synchronous to clk, edge-detected |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| host_irq | output | 10 | Registered host interrupt lines |

## Verification
The hardest case to reach is a clear and a fresh edge on the same event landing in the same cycle. The stimulus drives the clear write and the rising edge together on one falling clock edge, then reads the pending bit back. A second hard case is contention inside the priority resolver, where several channels and events compete for one host while some candidates are disabled or unrouted. The bench reaches it by programming both tables with arithmetic patterns that include out-of-range codes. It then loads pending bits through the set words in several dense patterns and compares all ten index words with a model of the ordering rule.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_EN   = 2;
  localparam int unsigned A_SET  = 4;
  localparam int unsigned A_CLR  = 6;
  localparam int unsigned A_EVM  = 16;
  localparam int unsigned A_CHM  = 24;
  localparam int unsigned A_IDX  = 32;
  localparam int unsigned CH_LSB = 8;
endpackage

// File: rtl/evt_capture.sv
module evt_capture #(
  parameter int N_EVT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [N_EVT-1:0] set_vec,
  input  logic [N_EVT-1:0] clr_vec,
  output logic [N_EVT-1:0] status
);
  logic [N_EVT-1:0] prev_q;
  logic [N_EVT-1:0] rise;

  assign rise = evt_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      status <= '0;
    end else begin
      prev_q <= evt_in;
      status <= (status & ~clr_vec) | rise | set_vec;
    end
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise) & ~status) == '0)); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~$past(clr_vec) & ~status) == '0)); // R3
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_vec & ~set_vec & ~rise) & status) == '0)); // R3
endmodule

// File: rtl/chan_winner.sv
module chan_winner #(
  parameter int N_EVT = 64,
  parameter int N_CH  = 10,
  parameter int IDX_W = 4,
  localparam int EVT_W = $clog2(N_EVT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_EVT-1:0]            active,
  input  logic [N_EVT-1:0][IDX_W-1:0] evmap,
  output logic [N_CH-1:0]             ch_any,
  output logic [N_CH-1:0][EVT_W-1:0]  ch_evt
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_comb begin
      ch_any[c] = 1'b0;
      ch_evt[c] = '0;
      for (int e = N_EVT - 1; e >= 0; e--) begin
        if (active[e] && evmap[e] == IDX_W'(c)) begin
          ch_any[c] = 1'b1;
          ch_evt[c] = EVT_W'(e);
        end
      end
    end

    AST_CH_PICK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      ch_any[c] |-> (active[ch_evt[c]] && evmap[ch_evt[c]] == IDX_W'(c))); // R6
  end
endmodule

// File: rtl/host_winner.sv
module host_winner #(
  parameter int N_CH  = 10,
  parameter int IDX_W = 4,
  parameter int EVT_W = 6,
  parameter int HOST  = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CH-1:0]            ch_any,
  input  logic [N_CH-1:0][EVT_W-1:0] ch_evt,
  input  logic [N_CH-1:0][IDX_W-1:0] chmap,
  output logic                       any,
  output logic [IDX_W-1:0]           win_ch,
  output logic [EVT_W-1:0]           win_evt
);
  always_comb begin
    any     = 1'b0;
    win_ch  = '0;
    win_evt = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (ch_any[c] && chmap[c] == IDX_W'(HOST)) begin
        any     = 1'b1;
        win_ch  = IDX_W'(c);
        win_evt = ch_evt[c];
      end
    end
  end

  AST_HOST_PICK_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (ch_any[win_ch] && chmap[win_ch] == IDX_W'(HOST))); // R9
endmodule

// File: rtl/intr_router.sv
module intr_router
  import intr_router_pkg::*;
#(
  parameter int N_EVT  = 64,
  parameter int N_CH   = 10,
  parameter int N_HOST = 10,
  parameter int IDX_W  = 4,
  parameter int AW     = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_HOST-1:0] host_irq
);
  localparam int EVT_W = $clog2(N_EVT);
  localparam int MPW   = DW / IDX_W;

  logic                        glb_en;
  logic [N_EVT-1:0]            en_q;
  logic [N_EVT-1:0][IDX_W-1:0] evmap_q;
  logic [N_CH-1:0][IDX_W-1:0]  chmap_q;
  logic [N_EVT-1:0]            status, set_vec, clr_vec;
  logic [N_CH-1:0]             ch_any;
  logic [N_CH-1:0][EVT_W-1:0]  ch_evt;
  logic [N_HOST-1:0]           host_any;
  logic [N_HOST-1:0][IDX_W-1:0] host_ch;
  logic [N_HOST-1:0][EVT_W-1:0] host_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      en_q    <= '0;
      evmap_q <= '0;
      chmap_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(A_CTRL)) glb_en <= bus_wdata[0];
      for (int e = 0; e < N_EVT; e++) begin
        if (bus_addr == AW'(A_EN + e / DW)) en_q[e] <= bus_wdata[e % DW];
        if (bus_addr == AW'(A_EVM + e / MPW))
          evmap_q[e] <= bus_wdata[(e % MPW) * IDX_W +: IDX_W];
      end
      for (int c = 0; c < N_CH; c++) begin
        if (bus_addr == AW'(A_CHM + c / MPW))
          chmap_q[c] <= bus_wdata[(c % MPW) * IDX_W +: IDX_W];
      end
    end
  end

  always_comb begin
    for (int e = 0; e < N_EVT; e++) begin
      set_vec[e] = bus_wr && bus_addr == AW'(A_SET + e / DW) && bus_wdata[e % DW];
      clr_vec[e] = bus_wr && bus_addr == AW'(A_CLR + e / DW) && bus_wdata[e % DW];
    end
  end

  evt_capture #(.N_EVT(N_EVT)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .set_vec(set_vec), .clr_vec(clr_vec), .status(status)
  );

  chan_winner #(.N_EVT(N_EVT), .N_CH(N_CH), .IDX_W(IDX_W)) u_chw (
    .clk(clk), .rst_n(rst_n), .active(status & en_q), .evmap(evmap_q),
    .ch_any(ch_any), .ch_evt(ch_evt)
  );

  for (genvar h = 0; h < N_HOST; h++) begin : g_host
    host_winner #(.N_CH(N_CH), .IDX_W(IDX_W), .EVT_W(EVT_W), .HOST(h)) u_hw (
      .clk(clk), .rst_n(rst_n), .ch_any(ch_any), .ch_evt(ch_evt),
      .chmap(chmap_q), .any(host_any[h]), .win_ch(host_ch[h]), .win_evt(host_evt[h])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_irq <= '0;
    else        host_irq <= glb_en ? host_any : '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_CTRL)) bus_rdata[0] = glb_en;
    for (int e = 0; e < N_EVT; e++) begin
      if (bus_addr == AW'(A_EN + e / DW)) bus_rdata[e % DW] = en_q[e];
      if (bus_addr == AW'(A_SET + e / DW) || bus_addr == AW'(A_CLR + e / DW))
        bus_rdata[e % DW] = status[e];
      if (bus_addr == AW'(A_EVM + e / MPW))
        bus_rdata[(e % MPW) * IDX_W +: IDX_W] = evmap_q[e];
    end
    for (int c = 0; c < N_CH; c++) begin
      if (bus_addr == AW'(A_CHM + c / MPW))
        bus_rdata[(c % MPW) * IDX_W +: IDX_W] = chmap_q[c];
    end
    for (int h = 0; h < N_HOST; h++) begin
      if (bus_addr == AW'(A_IDX + h)) begin
        bus_rdata[DW-1]              = host_any[h];
        bus_rdata[CH_LSB +: IDX_W]   = host_ch[h];
        bus_rdata[0 +: EVT_W]        = host_evt[h];
      end
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq != '0) |-> $past(glb_en)); // R10
  AST_IRQ_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((host_irq & ~$past(host_any)) == '0)); // R8
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    glb_en |=> ((host_irq ^ $past(host_any)) == '0)); // R8
endmodule

// File: tb/sim_intr_router.sv
module sim_intr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt_in = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  host_irq;

  intr_router u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_irq(host_irq)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_st, m_en;
  int m_evm [64];
  int m_chm [10];
  bit m_glb;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 6'(a);
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_idx(input int h);
    for (int c = 0; c < 10; c++)
      if (m_chm[c] == h)
        for (int e = 0; e < 64; e++)
          if (m_evm[e] == c && m_st[e] && m_en[e])
            return 32'h8000_0000 | 32'(c << 8) | 32'(e);
    return 32'h0;
  endfunction

  function automatic logic [9:0] exp_irq();
    logic [9:0] r = '0;
    for (int h = 0; h < 10; h++) r[h] = m_glb && exp_idx(h)[31];
    return r;
  endfunction

  task automatic push_maps();
    for (int w = 0; w < 8; w++) begin
      logic [31:0] d = '0;
      for (int j = 0; j < 8; j++) d[4*j +: 4] = 4'(m_evm[8*w + j]);
      wr(16 + w, d);
    end
    for (int w = 0; w < 2; w++) begin
      logic [31:0] d = '0;
      for (int j = 0; j < 8; j++) if (8*w + j < 10) d[4*j +: 4] = 4'(m_chm[8*w + j]);
      wr(24 + w, d);
    end
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    @(negedge clk);
    chk(req, 32'(host_irq), 32'(exp_irq()));
    for (int h = 0; h < 10; h++) begin
      rd(32 + h, d);
      chk(req, d, exp_idx(h));
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(a, d); chk("R1", d, 32'h0); end
    for (int a = 16; a < 26; a++) begin rd(a, d); chk("R1", d, 32'h0); end
    for (int a = 32; a < 42; a++) begin rd(a, d); chk("R1", d, 32'h0); end
    chk("R1", 32'(host_irq), 32'h0);

    // R6 R7 program tables, include out-of-range codes
    for (int e = 0; e < 64; e++) m_evm[e] = (e * 7 + 3) % 11;
    for (int c = 0; c < 10; c++) m_chm[c] = (c * 3 + 1) % 11;
    push_maps();
    for (int w = 0; w < 8; w++) begin
      logic [31:0] x = '0;
      for (int j = 0; j < 8; j++) x[4*j +: 4] = 4'(m_evm[8*w + j]);
      rd(16 + w, d); chk("R6", d, x);
    end
    rd(24, d);
    chk("R7", d, {4'(m_chm[7]), 4'(m_chm[6]), 4'(m_chm[5]), 4'(m_chm[4]),
                  4'(m_chm[3]), 4'(m_chm[2]), 4'(m_chm[1]), 4'(m_chm[0])});
    m_en = '1; m_glb = 1; m_st = '0;
    wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF); wr(0, 32'h1);
    rd(2, d); chk("R5", d, 32'hFFFF_FFFF);

    // R2 R8 R9 single-event sweep
    for (int e = 0; e < 64; e++) begin
      @(negedge clk); evt_in[e] = 1'b1;
      @(negedge clk); evt_in[e] = 1'b0;
      m_st = 64'h1 << e;
      rd(4 + e / 32, d); chk("R2", d, 32'h1 << (e % 32));
      check_all("R9");
      wr(6 + e / 32, 32'h1 << (e % 32));
      m_st = '0;
      rd(6 + e / 32, d); chk("R3", d, 32'h0);
    end

    // R4 R5 R9 dense patterns with partial enables
    for (int p = 0; p < 6; p++) begin
      m_st = {32'(p * 32'h9E37_79B1), 32'(p * 32'h85EB_CA6B + 5)};
      m_en = ~({32'(p * 32'h2545_F491), 32'(p * 32'h1B87_3593)} & 64'hF0F0_3C3C_A5A5_0FF0);
      wr(2, m_en[31:0]); wr(3, m_en[63:32]);
      wr(4, m_st[31:0]); wr(5, m_st[63:32]);
      rd(4, d); chk("R4", d, m_st[31:0]);
      rd(5, d); chk("R4", d, m_st[63:32]);
      check_all("R5");
      // R11 remap channels to other hosts
      for (int c = 0; c < 10; c++) m_chm[c] = (c * 3 + 1 + p) % 11;
      for (int w = 0; w < 2; w++) begin
        logic [31:0] x = '0;
        for (int j = 0; j < 8; j++) if (8*w + j < 10) x[4*j +: 4] = 4'(m_chm[8*w + j]);
        wr(24 + w, x);
      end
      check_all("R11");
      wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
      m_st = '0;
    end

    // R10 global enable off: lines low, index still live
    m_en = '1; wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
    m_glb = 0; wr(0, 32'h0);
    m_st = 64'h8000_0100_0020_0001; wr(4, m_st[31:0]); wr(5, m_st[63:32]);
    check_all("R10");
    m_glb = 1; wr(0, 32'h1);
    check_all("R10");
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF); m_st = '0;

    // R8 one-cycle latency: all events to channel 0, channel 0 to host 4
    for (int e = 0; e < 64; e++) m_evm[e] = 0;
    for (int c = 0; c < 10; c++) m_chm[c] = (c == 0) ? 4 : 10;
    push_maps();
    @(negedge clk); evt_in[40] = 1'b1;
    @(negedge clk);
    chk("R8", 32'(host_irq), 32'h0);
    @(negedge clk);
    chk("R8", 32'(host_irq), 32'h10);
    evt_in[40] = 1'b0;
    wr(7, 32'h1 << 8);
    @(negedge clk);
    chk("R8", 32'(host_irq), 32'h0);

    // R3 clear and new edge in the same cycle: bit stays set
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'd6; bus_wdata = 32'h8; evt_in[3] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(6, d); chk("R3", d, 32'h8);
    // R2 held high is not recaptured after clear
    wr(6, 32'h8);
    repeat (2) @(negedge clk);
    rd(6, d); chk("R2", d, 32'h0);
    chk("R2", 32'(host_irq), 32'h0);
    evt_in[3] = 1'b0;

    // R5 disabled event latches but stays silent
    m_en = ~64'h4; m_st = 64'h4;
    wr(2, m_en[31:0]);
    @(negedge clk); evt_in[2] = 1'b1;
    @(negedge clk); evt_in[2] = 1'b0;
    rd(4, d); chk("R5", d, 32'h4);
    check_all("R5");

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule